// File: doc/BRIEF.md
# Bit-Serial Accumulating Adder

This block adds two operands one bit per clock. It uses a single full adder and one carry flip-flop, so it is small and slow. Both operands sit in right-shifting registers. Each cycle the full adder takes the least significant bits of both registers together with the stored carry. The sum bit it produces enters the accumulator register at its top end. After WIDTH shifts the accumulator holds the sum, and its old contents are gone. The addend register rotates instead of shifting, so its contents come back to their starting value when the add finishes.

Software or a neighbouring controller works the block in three steps. It writes both operands through the parallel load ports. It pulses `start`. It then waits for the one-cycle `done` pulse and reads the sum, the unchanged addend and the final carry. While an add is running, the block ignores new loads and new start pulses.

Top module: `serial_accum_adder`

## Requirements
- R1: Synchronous active-high reset sets the accumulator, the addend, `busy`, `done` and `carry_out` all to zero.
- R2: While the block is idle, a high `load_acc` or `load_add` replaces that register with its parallel input at the next clock edge. The two loads act independently.
- R3: A `start` pulse seen while idle raises `busy` at the next edge. `busy` then stays high for exactly WIDTH cycles.
- R4: When the add completes, the accumulator holds (old accumulator + addend) modulo 2^WIDTH.
- R5: When the add completes, the addend register holds exactly the value it had before the add.
- R6: `carry_out` shows bit WIDTH of the full sum from the completion cycle until the next accepted start. An accepted start clears the carry first, so no earlier carry reaches a new add.
- R7: `done` is high for exactly one cycle. That cycle is the first cycle after the final shift, and `busy` is low in it.
- R8: Assertions of `load_acc` or `load_add` while `busy` is high have no effect on the registers.
- R9: A `start` seen while `busy` is high is ignored. The running add keeps its length and its result.
- R10: Processing is least significant bit first with right shifts. After k shifts, the top k bits of the accumulator hold sum bits k-1..0, its low WIDTH-k bits hold the old accumulator shifted right by k, and the addend is rotated right by k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| load_acc | input | 1 | Parallel load strobe for the accumulator |
| load_acc_val | input | WIDTH | Parallel value for the accumulator |
| load_add | input | 1 | Parallel load strobe for the addend |
| load_add_val | input | WIDTH | Parallel value for the addend |
| start | input | 1 | Begin an add (accepted only when idle) |
| busy | output | 1 | High while shifting |
| done | output | 1 | One-cycle completion pulse |
| acc_val | output | WIDTH | Accumulator contents |
| add_val | output | WIDTH | Addend contents |
| carry_out | output | 1 | Carry out of the most recent add |

## Verification
The bench builds the block with WIDTH = 4. At that width there are only 256 operand pairs, so the bench adds every one of them and compares the sum, the restored addend and the carry. The narrow width also lets the bench check the partial contents of both registers after every individual shift. It also makes every carry chain reachable, including the full ripple from 15 + 1 and the case where a carry must not leak into the next add.

// File: rtl/serial_add_pkg.sv
package serial_add_pkg;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;

    typedef struct packed {
        logic sum;
        logic cout;
    } fa_result_t;

    function automatic fa_result_t full_add(input logic x, input logic y, input logic cin);
        fa_result_t r;
        r.sum  = x ^ y ^ cin;
        r.cout = (x & y) | (x & cin) | (y & cin);
        return r;
    endfunction

endpackage

// File: rtl/sa_sequencer.sv
module sa_sequencer
    import serial_add_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy,
    output logic shift,
    output logic clear_carry,
    output logic done
);
    localparam int CW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
    localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

    seq_state_e    state;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SEQ_IDLE;
            cnt   <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                SEQ_IDLE: begin
                    if (start) begin
                        state <= SEQ_RUN;
                        cnt   <= '0;
                    end
                end
                SEQ_RUN: begin
                    if (cnt == LAST) begin
                        state <= SEQ_IDLE;
                        done  <= 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

    assign busy        = (state == SEQ_RUN);
    assign shift       = busy;
    assign clear_carry = (state == SEQ_IDLE) && start;

    // R7: completion pulse lasts one cycle
    assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7: done follows the last busy cycle
    assert_done_after_busy_R7: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));

    // R9: a running add advances every cycle whatever start does
    assert_cnt_advance_R9: assert property (@(posedge clk) disable iff (rst)
        (busy && cnt != LAST) |=> (busy && cnt == $past(cnt) + 1'b1));

    // R3: an idle start always launches
    assert_start_launch_R3: assert property (@(posedge clk) disable iff (rst)
        (!busy && start) |=> (busy && cnt == '0));

endmodule

// File: rtl/sa_shift_reg.sv
module sa_shift_reg #(
    parameter int WIDTH  = 4,
    parameter bit RECIRC = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [WIDTH-1:0] load_val,
    input  logic             shift,
    input  logic             serial_in,
    output logic [WIDTH-1:0] q,
    output logic             lsb
);
    logic feed;

    always_comb feed = RECIRC ? q[0] : serial_in;

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (shift) begin
            q <= {feed, q[WIDTH-1:1]};
        end else if (load) begin
            q <= load_val;
        end
    end

    assign lsb = q[0];

    // R8: a shift in progress overrides any load request
    assert_shift_wins_R8: assert property (@(posedge clk) disable iff (rst)
        (shift && load) |=> (q[WIDTH-2:0] == $past(q[WIDTH-1:1])));

    generate
        if (RECIRC) begin : g_rotate
            // R5: the bit leaving at the bottom re-enters at the top
            assert_rotate_R5: assert property (@(posedge clk) disable iff (rst)
                shift |=> (q[WIDTH-1] == $past(q[0])));
        end else begin : g_serial
            // R10: the serial input enters at the top end
            assert_serial_top_R10: assert property (@(posedge clk) disable iff (rst)
                shift |=> (q[WIDTH-1] == $past(serial_in)));
        end
    endgenerate

endmodule

// File: rtl/sa_carry_unit.sv
module sa_carry_unit
    import serial_add_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic a_bit,
    input  logic b_bit,
    input  logic shift,
    input  logic clear,
    output logic sum_bit,
    output logic carry_q
);
    fa_result_t fa;

    always_comb fa = full_add(a_bit, b_bit, carry_q);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            carry_q <= 1'b0;
        end else if (shift) begin
            carry_q <= fa.cout;
        end
    end

    assign sum_bit = fa.sum;

    // R6: carry holds between adds
    assert_carry_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (!shift && !clear) |=> $stable(carry_q));

    // R6: a new add starts with a cleared carry
    assert_carry_clear_R6: assert property (@(posedge clk) disable iff (rst)
        clear |=> !carry_q);

endmodule

// File: rtl/serial_accum_adder.sv
module serial_accum_adder
    import serial_add_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_acc,
    input  logic [WIDTH-1:0] load_acc_val,
    input  logic             load_add,
    input  logic [WIDTH-1:0] load_add_val,
    input  logic             start,
    output logic             busy,
    output logic             done,
    output logic [WIDTH-1:0] acc_val,
    output logic [WIDTH-1:0] add_val,
    output logic             carry_out
);
    logic shift;
    logic clear_carry;
    logic acc_lsb;
    logic add_lsb;
    logic sum_bit;
    logic acc_load_ok;
    logic add_load_ok;

    sa_sequencer #(.WIDTH(WIDTH)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .busy        (busy),
        .shift       (shift),
        .clear_carry (clear_carry),
        .done        (done)
    );

    assign acc_load_ok = load_acc && !busy;
    assign add_load_ok = load_add && !busy;

    sa_shift_reg #(.WIDTH(WIDTH), .RECIRC(1'b0)) u_acc_reg (
        .clk       (clk),
        .rst       (rst),
        .load      (acc_load_ok),
        .load_val  (load_acc_val),
        .shift     (shift),
        .serial_in (sum_bit),
        .q         (acc_val),
        .lsb       (acc_lsb)
    );

    sa_shift_reg #(.WIDTH(WIDTH), .RECIRC(1'b1)) u_add_reg (
        .clk       (clk),
        .rst       (rst),
        .load      (add_load_ok),
        .load_val  (load_add_val),
        .shift     (shift),
        .serial_in (1'b0),
        .q         (add_val),
        .lsb       (add_lsb)
    );

    sa_carry_unit u_carry (
        .clk     (clk),
        .rst     (rst),
        .a_bit   (acc_lsb),
        .b_bit   (add_lsb),
        .shift   (shift),
        .clear   (clear_carry),
        .sum_bit (sum_bit),
        .carry_q (carry_out)
    );

    // R2: idle loads land on the next edge
    assert_acc_load_R2: assert property (@(posedge clk) disable iff (rst)
        (!busy && load_acc) |=> (acc_val == $past(load_acc_val)));

    assert_add_load_R2: assert property (@(posedge clk) disable iff (rst)
        (!busy && load_add) |=> (add_val == $past(load_add_val)));

    // R8: idle without load keeps both operands
    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!busy && !load_acc && !load_add) |=> ($stable(acc_val) && $stable(add_val)));

endmodule

// File: tb/serial_accum_adder_bench.sv
module serial_accum_adder_bench;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         load_acc = 1'b0;
    logic [W-1:0] load_acc_val = '0;
    logic         load_add = 1'b0;
    logic [W-1:0] load_add_val = '0;
    logic         start = 1'b0;
    logic         busy;
    logic         done;
    logic [W-1:0] acc_val;
    logic [W-1:0] add_val;
    logic         carry_out;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    serial_accum_adder #(.WIDTH(W)) u_serial_accum_adder (
        .clk          (clk),
        .rst          (rst),
        .load_acc     (load_acc),
        .load_acc_val (load_acc_val),
        .load_add     (load_add),
        .load_add_val (load_add_val),
        .start        (start),
        .busy         (busy),
        .done         (done),
        .acc_val      (acc_val),
        .add_val      (add_val),
        .carry_out    (carry_out)
    );

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [W-1:0] rotr(input logic [W-1:0] v, input int k);
        logic [W-1:0] r = v;
        for (int i = 0; i < k; i++) r = {r[0], r[W-1:1]};
        return r;
    endfunction

    task automatic load_both(input logic [W-1:0] a, input logic [W-1:0] b);
        load_acc = 1'b1; load_acc_val = a;
        load_add = 1'b1; load_add_val = b;
        step();
        load_acc = 1'b0; load_add = 1'b0;
        chk("R2", "acc after load", acc_val, a);
        chk("R2", "add after load", add_val, b);
    endtask

    // full add with per-shift checks when detail is set
    task automatic run_add(input logic [W-1:0] a, input logic [W-1:0] b, input bit detail);
        logic [W:0] s = {1'b0, a} + {1'b0, b};
        start = 1'b1;
        step();
        start = 1'b0;
        chk("R3", "busy after start", busy, 1);
        for (int k = 1; k <= W; k++) begin
            step();
            if (k < W) begin
                chk("R3", "busy mid add", busy, 1);
                if (detail) begin
                    chk("R10", "acc top bits", acc_val >> (W - k), s & ((1 << k) - 1));
                    chk("R10", "acc low bits", acc_val & ((1 << (W - k)) - 1), a >> k);
                    chk("R10", "addend rotation", add_val, rotr(b, k));
                end
            end
        end
        chk("R3", "busy drops after W", busy, 0);
        chk("R7", "done pulse", done, 1);
        chk("R4", "sum", acc_val, s[W-1:0]);
        chk("R5", "addend restored", add_val, b);
        chk("R6", "carry out", carry_out, s[W]);
        step();
        chk("R7", "done one cycle", done, 0);
        chk("R6", "carry held", carry_out, s[W]);
    endtask

    task automatic t_reset();
        chk("R1", "acc reset", acc_val, 0);
        chk("R1", "add reset", add_val, 0);
        chk("R1", "busy reset", busy, 0);
        chk("R1", "done reset", done, 0);
        chk("R1", "carry reset", carry_out, 0);
    endtask

    task automatic t_independent_loads();
        load_both(4'h3, 4'h5);
        load_acc = 1'b1; load_acc_val = 4'hA;
        step();
        load_acc = 1'b0;
        chk("R2", "acc alone", acc_val, 4'hA);
        chk("R2", "add untouched", add_val, 4'h5);
    endtask

    task automatic t_progress();
        load_both(4'hB, 4'h6);
        run_add(4'hB, 4'h6, 1'b1);
        load_both(4'h9, 4'hE);
        run_add(4'h9, 4'hE, 1'b1);
    endtask

    task automatic t_carry_clear();
        load_both(4'hF, 4'h1);
        run_add(4'hF, 4'h1, 1'b0);
        load_both(4'h0, 4'h0);
        run_add(4'h0, 4'h0, 1'b0);
        chk("R6", "no stale carry sum", acc_val, 0);
    endtask

    task automatic t_load_busy();
        load_both(4'h6, 4'h3);
        start = 1'b1;
        step();
        start = 1'b0;
        load_acc = 1'b1; load_acc_val = 4'hF;
        load_add = 1'b1; load_add_val = 4'hF;
        for (int k = 1; k <= W; k++) step();
        load_acc = 1'b0; load_add = 1'b0;
        chk("R8", "acc ignores busy load", acc_val, 4'h9);
        chk("R8", "add ignores busy load", add_val, 4'h3);
        step();
        chk("R8", "acc after busy", acc_val, 4'h9);
    endtask

    task automatic t_start_busy();
        int n = 0;
        load_both(4'h7, 4'h7);
        start = 1'b1;
        step();
        while (busy && n < 20) begin
            n++;
            step();
        end
        start = 1'b0;
        chk("R9", "busy length", n, W);
        chk("R9", "sum unaffected", acc_val, 4'hE);
        chk("R9", "done pulse", done, 1);
        step();
        step();
    endtask

    task automatic t_exhaustive();
        for (int a = 0; a < 16; a++)
            for (int b = 0; b < 16; b++) begin
                load_both(W'(a), W'(b));
                run_add(W'(a), W'(b), 1'b0);
            end
    endtask

    initial begin
        repeat (3) step();
        rst = 1'b0;
        t_reset();
        t_independent_loads();
        t_progress();
        t_carry_clear();
        t_load_busy();
        t_start_busy();
        t_exhaustive();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule